// File: doc/BRIEF.md
# DAC Output Clear and Load Controller

This block is the digital control for an eight-channel digital-to-analog converter. Each channel has three stages of state. A data register is written by an internal update engine. A latch captures that register when the load input is active. An output code register feeds the converter. Two asynchronous inputs, both active low, steer the outputs. The clear input forces every converter to the zero code and turns the output buffers off. The load input moves data register contents into the latches.

Clearing never alters stored contents. Once a clear is released, the outputs come back only through a load. If the load input is already low at the moment of release, the outputs return at once. If it is high, they stay at zero until it next goes low. Any load activity during the clear is discarded.

Writes enter through a small update engine. The engine holds a status flag for a fixed number of cycles and, for the same cycles, drives the enable of an open-drain busy pad. When the engine finishes, the pad is released rather than driven high, so several devices can share one wired busy line. That line reads high only once every device on it is idle.

Top module: `dac_clr_ld_ctrl`

## Requirements
- R1: While the synchronised clear is low, every channel's output code is zero and `out_en` is 0. `out_en` also drops combinationally as soon as `clr_n` goes low.
- R2: Load activity on `ld_n` while clear is low is discarded. If clear is then released with `ld_n` high, the outputs remain zero.
- R3: If clear is released while `ld_n` is high, the outputs stay zero and `out_en` stays 0 until `ld_n` is next driven low. At that point the latched values appear.
- R4: If `ld_n` is held low across the release of clear, the stored values appear on the outputs as soon as the release has been synchronised.
- R5: A clear leaves the data registers and the latches unchanged. This includes data written by the engine while the clear is active.
- R6: A write raises `busy_flag` and `busy_pd` together for exactly UPD_CYCLES clock cycles, after which both return to 0. `busy_pd` = 1 means the pad is pulled low; `busy_pd` = 0 means the pad is released.
- R7: A write commits `wr_data` to the data register of channel `wr_ch` only. Channel i occupies bits [16*i+15:16*i] of `dac_code`.
- R8: With clear inactive, `ld_n` low makes each latch follow its data register, and the output shows it. With `ld_n` high, a committed write does not change the output.
- R9: A write request that arrives while `busy_flag` is 1 is ignored.
- R10: After reset, every output code is zero, `out_en` is 0, the outputs are in the cleared state, and `busy_flag` and `busy_pd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Asynchronous clear request, active low |
| ld_n | input | 1 | Asynchronous load request, active low |
| wr_en | input | 1 | Start an update of one channel |
| wr_ch | input | 3 | Channel selected for the update |
| wr_data | input | 16 | Code to commit to the selected data register |
| dac_code | output | 128 | Converter codes; channel i at bits [16*i+15:16*i] |
| out_en | output | 1 | Output buffer enable; 0 means high impedance |
| busy_flag | output | 1 | Status bit, 1 while the update engine runs |
| busy_pd | output | 1 | Open-drain pull-down enable for the shared busy pad |

## Verification
A wrong cleared flag is visible at the ports within three clock edges of a change on a pin. There are two ways it can go wrong. A flag that clears too early shows latch values on `dac_code` after a release with load high. A flag that stays set shows zeros after a load. A latch that moved during a clear shows up as a wrong code on the first load with no fresh write. An engine with the wrong timing shows up in two ways: a busy window that is not exactly UPD_CYCLES cycles long, or a second write sneaking into a channel.

// File: rtl/dac_clr_ld_pkg.sv
package dac_clr_ld_pkg;
  typedef enum logic {ENG_IDLE, ENG_RUN} eng_st_e;

  typedef struct packed {
    logic clr_act;
    logic ld_act;
  } ctl_s;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_VAL}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/dac_clr_seq.sv
module dac_clr_seq
  import dac_clr_ld_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr_s,
  input  logic ld_s,
  output ctl_s ctl,
  output logic cleared_nx
);
  logic cleared_q;

  // Load counts only while clear is inactive; the flag falls only on such a load
  always_comb begin
    ctl.clr_act = ~clr_s;
    ctl.ld_act  = ~ld_s & clr_s;
    if (ctl.clr_act)     cleared_nx = 1'b1;
    else if (ctl.ld_act) cleared_nx = 1'b0;
    else                 cleared_nx = cleared_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cleared_q <= 1'b1;
    else     cleared_q <= cleared_nx;
  end
endmodule

// File: rtl/dac_upd_engine.sv
module dac_upd_engine
  import dac_clr_ld_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int DW         = 16,
  parameter int UPD_CYCLES = 6,
  localparam int CHW  = $clog2(NCH),
  localparam int CNTW = $clog2(UPD_CYCLES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [DW-1:0]  wr_data,
  output logic           busy,
  output logic           commit,
  output logic [CHW-1:0] commit_ch,
  output logic [DW-1:0]  commit_data
);
  eng_st_e        st_q;
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ENG_IDLE;
      cnt_q       <= '0;
      commit_ch   <= '0;
      commit_data <= '0;
    end else begin
      case (st_q)
        ENG_IDLE: if (wr_en) begin
          st_q        <= ENG_RUN;
          cnt_q       <= CNTW'(UPD_CYCLES - 1);
          commit_ch   <= wr_ch;
          commit_data <= wr_data;
        end
        ENG_RUN: begin
          if (cnt_q == '0) st_q <= ENG_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy   = (st_q == ENG_RUN);
  assign commit = busy && (cnt_q == '0);
endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank #(
  parameter int NCH = 8,
  parameter int DW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [CHW-1:0]    commit_ch,
  input  logic [DW-1:0]     commit_data,
  input  logic              xfer,
  input  logic              cleared_nx,
  output logic [NCH*DW-1:0] code_flat,
  output logic [NCH*DW-1:0] latch_flat
);
  logic [DW-1:0] data_q  [NCH];
  logic [DW-1:0] latch_q [NCH];
  logic [DW-1:0] latch_nx[NCH];
  logic [DW-1:0] code_q  [NCH];

  always_comb begin
    for (int i = 0; i < NCH; i++)
      latch_nx[i] = xfer ? data_q[i] : latch_q[i];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (rst) begin
        data_q[i]  <= '0;
        latch_q[i] <= '0;
        code_q[i]  <= '0;
      end else begin
        if (commit && commit_ch == CHW'(i)) data_q[i] <= commit_data;
        latch_q[i] <= latch_nx[i];
        code_q[i]  <= cleared_nx ? '0 : latch_nx[i];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign code_flat[g*DW +: DW]  = code_q[g];
    assign latch_flat[g*DW +: DW] = latch_q[g];
  end
endmodule

// File: rtl/dac_clr_ld_ctrl.sv
module dac_clr_ld_ctrl
  import dac_clr_ld_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int DW          = 16,
  parameter int UPD_CYCLES  = 6,
  parameter int SYNC_STAGES = 2,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              ld_n,
  input  logic              wr_en,
  input  logic [CHW-1:0]    wr_ch,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH*DW-1:0] dac_code,
  output logic              out_en,
  output logic              busy_flag,
  output logic              busy_pd
);
  logic              clr_s, ld_s;
  ctl_s              ctl;
  logic              cleared_nx;
  logic              eng_busy, commit;
  logic [CHW-1:0]    commit_ch;
  logic [DW-1:0]     commit_data;
  logic [NCH*DW-1:0] latch_flat;
  logic              oe_q;

  dac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clr (
    .clk(clk), .rst(rst), .d(clr_n), .q(clr_s));
  dac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ld (
    .clk(clk), .rst(rst), .d(ld_n), .q(ld_s));

  dac_clr_seq u_seq (
    .clk(clk), .rst(rst), .clr_s(clr_s), .ld_s(ld_s),
    .ctl(ctl), .cleared_nx(cleared_nx));

  dac_upd_engine #(.NCH(NCH), .DW(DW), .UPD_CYCLES(UPD_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .busy(eng_busy), .commit(commit), .commit_ch(commit_ch),
    .commit_data(commit_data));

  dac_chan_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst(rst), .commit(commit), .commit_ch(commit_ch),
    .commit_data(commit_data), .xfer(ctl.ld_act), .cleared_nx(cleared_nx),
    .code_flat(dac_code), .latch_flat(latch_flat));

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= ~cleared_nx;
  end

  // Raw pin gates the enable so the buffer turns off before synchronisation
  assign out_en    = oe_q & clr_n;
  assign busy_flag = eng_busy;
  assign busy_pd   = eng_busy;
endmodule

// File: rtl/dac_clr_ld_chk.sv
module dac_clr_ld_chk #(
  parameter int NCH = 8,
  parameter int DW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_s,
  input logic              ld_s,
  input logic              wr_en,
  input logic [NCH*DW-1:0] latch_flat,
  input logic [NCH*DW-1:0] dac_code,
  input logic              out_en,
  input logic              busy_flag
);
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    !clr_s |=> (dac_code == '0)); // R1
  AST_CLR_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    !clr_s |=> !out_en); // R1
  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !clr_s |=> $stable(latch_flat)); // R5
  AST_RELEASE_HIGH_STAYS: assert property (@(posedge clk) disable iff (rst)
    (clr_s && $past(!clr_s) && ld_s) |=> (dac_code == '0)); // R3
  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_flag) |-> $past(wr_en)); // R6
endmodule

bind dac_clr_ld_ctrl dac_clr_ld_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .clr_s(clr_s), .ld_s(ld_s), .wr_en(wr_en),
  .latch_flat(latch_flat), .dac_code(dac_code), .out_en(out_en),
  .busy_flag(busy_flag));

// File: tb/dac_clr_ld_ctrl_test.sv
module dac_clr_ld_ctrl_test;
  localparam int NCH = 8;
  localparam int DW  = 16;
  localparam int UPD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_n = 1'b1, ld_n = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_ch = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NCH*DW-1:0] dac_code;
  logic out_en, busy_flag, busy_pd;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] exp_v[NCH];

  // {channel, data}
  localparam logic [18:0] VEC [8] = '{
    {3'd5, 16'hA5A5}, {3'd0, 16'h0001}, {3'd7, 16'hFFFF}, {3'd2, 16'h1234},
    {3'd0, 16'h8000}, {3'd6, 16'h00FF}, {3'd1, 16'h7FFE}, {3'd3, 16'hC3C3}};

  dac_clr_ld_ctrl #(.NCH(NCH), .DW(DW), .UPD_CYCLES(UPD)) uut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .ld_n(ld_n), .wr_en(wr_en),
    .wr_ch(wr_ch), .wr_data(wr_data), .dac_code(dac_code), .out_en(out_en),
    .busy_flag(busy_flag), .busy_pd(busy_pd));

  always #4 clk = ~clk;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_flat();
    logic [127:0] f;
    for (int i = 0; i < NCH; i++) f[i*DW +: DW] = exp_v[i];
    return f;
  endfunction

  task automatic wr(logic [2:0] ch, logic [DW-1:0] d);
    wr_en = 1'b1; wr_ch = ch; wr_data = d;
    tick(1);
    wr_en = 1'b0;
    while (busy_flag) tick(1);
    tick(2);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) exp_v[i] = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R10 code", dac_code, '0);
    chk("R10 oe", 128'(out_en), 128'(0));
    chk("R10 busy", 128'({busy_flag, busy_pd}), 128'(0));
    tick(4);
    chk("R10 stays cleared", 128'(out_en), 128'(0));

    ld_n = 1'b0;
    tick(4);
    chk("R8 oe after load", 128'(out_en), 128'(1));
    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][18:16], VEC[v][15:0]);
      exp_v[VEC[v][18:16]] = VEC[v][15:0];
      chk("R7 R8 vector", dac_code, exp_flat());
    end

    // busy window length and write-while-busy
    begin
      int hi = 0;
      bit pin_ok = 1;
      wr_en = 1'b1; wr_ch = 3'd4; wr_data = 16'h1111;
      tick(1);
      wr_en = 1'b0;
      tick(1);
      wr_en = 1'b1; wr_data = 16'h2222;
      tick(1);
      wr_en = 1'b0;
      for (int c = 0; c < 20; c++) begin
        if (busy_flag) hi++;
        if (busy_pd !== busy_flag) pin_ok = 0;
        tick(1);
      end
      chk("R6 busy length", 128'(hi + 2), 128'(UPD));
      chk("R6 pin follows", 128'(pin_ok), 128'(1));
      chk("R6 released", 128'({busy_flag, busy_pd}), 128'(0));
      exp_v[4] = 16'h1111;
      chk("R9 write while busy", dac_code, exp_flat());
    end

    clr_n = 1'b0;
    #1;
    chk("R1 oe comb", 128'(out_en), 128'(0));
    tick(4);
    chk("R1 zero", dac_code, '0);
    clr_n = 1'b1;
    tick(4);
    chk("R4 ld low release", dac_code, exp_flat());
    chk("R4 oe", 128'(out_en), 128'(1));

    ld_n = 1'b1;
    tick(4);
    clr_n = 1'b0;
    tick(4);
    wr(3'd2, 16'h4444);
    ld_n = 1'b0; tick(4); ld_n = 1'b1; tick(4);
    clr_n = 1'b1;
    tick(6);
    chk("R2 R3 still zero", dac_code, '0);
    chk("R3 oe off", 128'(out_en), 128'(0));
    ld_n = 1'b0;
    tick(4);
    exp_v[2] = 16'h4444;
    chk("R3 R5 after load", dac_code, exp_flat());

    ld_n = 1'b1;
    tick(4);
    wr(3'd7, 16'h0F0F);
    chk("R8 ld high holds", dac_code, exp_flat());
    ld_n = 1'b0;
    tick(4);
    exp_v[7] = 16'h0F0F;
    chk("R8 load new", dac_code, exp_flat());

    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
    chk("R10 reset again", dac_code, '0);
    chk("R10 oe again", 128'(out_en), 128'(0));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule